// File: doc/BRIEF.md
# External Pattern Memory Cycle Sequencer

This block turns single-word requests from an on-chip client into bus cycles on an external parallel memory (mask ROM, SRAM or NOR flash). Each cycle's length is a count of system clocks taken from three configuration fields. One field sets the length of a random-access strobe. One sets the length of a page-mode read beat. One sets the bus-release period that separates a finished access from the next one.

A read whose upper address matches the word just read continues in page mode. The read strobe stays low, only the low `PAGE_BITS` address bits change, and the shorter page count applies. Any other follow-on access first closes the current one with the release period, and then starts a fresh random cycle. An active-low float input disconnects the address, data and strobe drivers. While it is low, the sequencer freezes in place, so no request is dropped and no beat is cut short.

Top module: `pmem_seq`

## Requirements
- R1: After reset, both strobes are high (inactive), the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: A read accepted from idle holds `mem_oe_n` low with a stable address for exactly `cfg_rand_clks`+1 enabled clocks. On the clock after the last of these, `rsp_valid` pulses, carrying the data that was present on `mem_dq_in` during that last clock.
- R3: A read request present on the last clock of a read beat, whose address bits above bit `PAGE_BITS`-1 equal those of the current address, is accepted on that clock. `mem_oe_n` stays low, and the new address drives a beat lasting `cfg_page_clks`+1 enabled clocks, with its own response.
- R4: When an access is not continued in page mode, both strobes stay high for `cfg_float_clks`+1 release clocks plus one idle clock. A waiting request therefore sees exactly `cfg_float_clks`+2 enabled strobe-free clocks between two strobes.
- R5: A write holds `mem_we_n` low for exactly `cfg_rand_clks`+1 enabled clocks with `mem_oe_n` high. The write data is driven with a stable address throughout the strobe and during the first release clock, and the data bus is released on the second release clock. A write produces no response.
- R6: A read that follows a write, or a read to a different upper address, never continues in page mode. It goes through the release period of R4.
- R7: While `hiz_n` is low, `mem_addr_oe`, `mem_dq_oe` and `mem_ctl_oe` are all low and `req_ready` is low.
- R8: While `hiz_n` is low, the sequencer's state does not advance. An interrupted beat resumes and counts only enabled clocks, and every accepted request yields exactly one beat.
- R9: A request is taken only on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only when idle or on a page-continuation clock, and never during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request taken on this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (26) | Word address |
| req_wdata | input | DW (16) | Write data |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | DW (16) | Read data |
| cfg_float_clks | input | 2 | Release clocks minus one |
| cfg_rand_clks | input | 4 | Random strobe clocks minus one |
| cfg_page_clks | input | 3 | Page beat clocks minus one |
| hiz_n | input | 1 | Active-low bus float and freeze request |
| mem_addr | output | AW (26) | Memory address |
| mem_addr_oe | output | 1 | Address driver enable |
| mem_dq_out | output | DW (16) | Write data to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DW (16) | Read data from memory |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ctl_oe | output | 1 | Strobe driver enable |

## Verification
The bench goes after the page boundary: a read of word 8 after word 7 must start a new random cycle. A design that compared the wrong bits would continue in page mode there, and the bench would see a short beat with no release gap. It also runs the extremes of all three counts (all zero, all maximal), where an off-by-one shows up as a beat or gap one clock long or short. It mixes writes and reads on one page, to catch a write followed by a read wrongly merged into a page beat and to catch data held too short or too long after a write. It pulses `hiz_n` in the middle of beats, during release and while a request waits. A design that kept counting would shorten the observed beats, and one that accepted during float would lose a scoreboard entry.

// File: rtl/pmem_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the pattern memory sequencer.
// Assumes: field widths below are fixed by the register layout.
package pmem_seq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RAND  = 2'd1,
        SQ_PAGE  = 2'd2,
        SQ_FLOAT = 2'd3
    } sq_state_t;

    localparam int FLT_W = 2;
    localparam int RND_W = 4;
    localparam int PG_W  = 3;
    localparam int CNT_W = (RND_W > PG_W) ? ((RND_W > FLT_W) ? RND_W : FLT_W)
                                          : ((PG_W > FLT_W) ? PG_W : FLT_W);

endpackage

// File: rtl/pmem_cycle_timer.sv
`timescale 1ns/1ps
// Phase length counter: counts enabled clocks from zero and flags the
// first and the final clock of a phase whose last index is `limit`.
// Assumes: `limit` is stable for the whole phase; `restart` is raised
// on the clock that ends a phase (and continuously while idle).
module pmem_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             last,
    output logic             first
);

    logic [CNT_W-1:0] cnt_q;

    // Count enabled clocks; restart from zero at a phase boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= restart ? '0 : cnt_q + 1'b1;
        end
    end

    assign last  = (cnt_q == limit);
    assign first = (cnt_q == '0);

    // R2 R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

endmodule

// File: rtl/pmem_page_match.sv
`timescale 1ns/1ps
// Page comparator: reports whether a new request lies in the same page
// (same upper address bits) as the word currently on the bus.
// Assumes: callers pass only the bits above the page offset.
module pmem_page_match #(
    parameter int UW = 23
) (
    input  logic [UW-1:0] cur_upper,
    input  logic [UW-1:0] next_upper,
    output logic          same
);

    // Equality of the page numbers
    always_comb begin
        same = (cur_upper == next_upper);
    end

endmodule

// File: rtl/pmem_seq.sv
`timescale 1ns/1ps
// External pattern memory cycle sequencer.
// Runs random reads, page-mode reads and writes with clock counts taken
// from the cfg_* fields, separates non-page accesses by a release period,
// and floats and freezes the bus while hiz_n is low.
// Assumes: cfg_* change only while the sequencer is idle; PAGE_BITS < AW.
module pmem_seq
    import pmem_seq_pkg::*;
#(
    parameter int AW        = 26,
    parameter int DW        = 16,
    parameter int PAGE_BITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    input  logic [FLT_W-1:0] cfg_float_clks,
    input  logic [RND_W-1:0] cfg_rand_clks,
    input  logic [PG_W-1:0]  cfg_page_clks,
    input  logic             hiz_n,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_addr_oe,
    output logic [DW-1:0]    mem_dq_out,
    output logic             mem_dq_oe,
    input  logic [DW-1:0]    mem_dq_in,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             mem_ctl_oe
);

    localparam int UW = AW - PAGE_BITS;

    sq_state_t        st_q, st_d;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             wr_q;
    logic             rsp_valid_q;
    logic [DW-1:0]    rsp_rdata_q;
    logic [CNT_W-1:0] limit;
    logic             t_last, t_first, restart;
    logic             upper_eq, in_access, page_ok, take;

    // Phase length selection
    always_comb begin
        unique case (st_q)
            SQ_RAND:  limit = CNT_W'(cfg_rand_clks);
            SQ_PAGE:  limit = CNT_W'(cfg_page_clks);
            SQ_FLOAT: limit = CNT_W'(cfg_float_clks);
            default:  limit = '0;
        endcase
    end

    pmem_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (hiz_n),
        .restart (restart),
        .limit   (limit),
        .last    (t_last),
        .first   (t_first)
    );

    pmem_page_match #(.UW(UW)) u_match (
        .cur_upper  (addr_q[AW-1:PAGE_BITS]),
        .next_upper (req_addr[AW-1:PAGE_BITS]),
        .same       (upper_eq)
    );

    assign in_access = (st_q == SQ_RAND) || (st_q == SQ_PAGE);
    assign page_ok   = in_access && t_last && !wr_q && !req_write && upper_eq;
    assign req_ready = hiz_n && ((st_q == SQ_IDLE) || page_ok);

    // Next phase and request acceptance
    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        take    = 1'b0;
        unique case (st_q)
            SQ_IDLE: begin
                restart = 1'b1;
                if (req_valid) begin
                    take = 1'b1;
                    st_d = SQ_RAND;
                end
            end
            SQ_RAND, SQ_PAGE: begin
                if (t_last) begin
                    restart = 1'b1;
                    if (page_ok && req_valid) begin
                        take = 1'b1;
                        st_d = SQ_PAGE;
                    end else begin
                        st_d = SQ_FLOAT;
                    end
                end
            end
            default: begin
                if (t_last) begin
                    restart = 1'b1;
                    st_d    = SQ_IDLE;
                end
            end
        endcase
    end

    // Phase, address and write data registers; frozen while floated
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SQ_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (hiz_n) begin
            st_q <= st_d;
            if (take) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                wr_q    <= req_write;
            end
        end
    end

    // Read data capture on the last clock of a read beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= hiz_n && in_access && t_last && !wr_q;
            if (hiz_n && in_access && t_last && !wr_q) begin
                rsp_rdata_q <= mem_dq_in;
            end
        end
    end

    assign rsp_valid   = rsp_valid_q;
    assign rsp_rdata   = rsp_rdata_q;
    assign mem_addr    = addr_q;
    assign mem_dq_out  = wdata_q;
    assign mem_addr_oe = hiz_n;
    assign mem_ctl_oe  = hiz_n;
    assign mem_dq_oe   = hiz_n && wr_q &&
                         ((st_q == SQ_RAND) || ((st_q == SQ_FLOAT) && t_first));
    assign mem_oe_n    = !(in_access && !wr_q);
    assign mem_we_n    = !((st_q == SQ_RAND) && wr_q);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_n |=> ($stable(st_q) && $stable(addr_q)));

    // R3
    page_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_PAGE) |-> (addr_q[AW-1:PAGE_BITS] == $past(addr_q[AW-1:PAGE_BITS])));

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n && hiz_n));

    // R9
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!mem_oe_n || !mem_we_n));

    // R7
    hiz_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hiz_n |-> (!mem_addr_oe && !mem_dq_oe && !mem_ctl_oe && !req_ready));

endmodule

// File: tb/pmem_seq_bench.sv
`timescale 1ns/1ps
module pmem_seq_bench;

    localparam int AW = 26;
    localparam int DW = 16;
    localparam int PB = 3;

    typedef struct {
        bit              wr;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        int              len;
        int              gap;   // -1 unchecked, -2 page continuation, else exact
    } beat_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0] cfg_f = 2'd1;
    logic [3:0] cfg_r = 4'd2;
    logic [2:0] cfg_p = 3'd1;
    logic hiz_n = 1'b1;
    logic req_ready, rsp_valid, mem_addr_oe, mem_dq_oe, mem_oe_n, mem_we_n, mem_ctl_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int total = 0, bad = 0;
    beat_t bq[$];
    logic [DW-1:0] rq[$];
    bit chain = 0, prev_wr = 0;
    logic [AW-1:0] prev_addr = '0;
    bit mon_on = 0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[25:16], 6'b0};
    endfunction

    assign mem_dq_in = (mem_ctl_oe && !mem_oe_n) ? model(mem_addr) : 16'hDEAD;

    pmem_seq u_pmem_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_float_clks(cfg_f), .cfg_rand_clks(cfg_r), .cfg_page_clks(cfg_p),
        .hiz_n(hiz_n),
        .mem_addr(mem_addr), .mem_addr_oe(mem_addr_oe),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ctl_oe(mem_ctl_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: presents one request, predicts its beat, pushes expectations
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        beat_t e;
        bit page;
        page = chain && !wr && !prev_wr && (a[AW-1:PB] == prev_addr[AW-1:PB]);
        e.wr   = wr;
        e.addr = a;
        e.data = d;
        e.len  = page ? int'(cfg_p) + 1 : int'(cfg_r) + 1;
        e.gap  = page ? -2 : (chain ? int'(cfg_f) + 2 : -1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        bq.push_back(e);
        if (!wr) rq.push_back(model(a));
        @(negedge clk);
        req_valid = 1'b0;
        chain     = 1;
        prev_wr   = wr;
        prev_addr = a;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
        chain = 0;
    endtask

    // Monitor state
    beat_t cur;
    bit in_beat = 0, last_wr = 0, wok = 1;
    int len = 0, gapcnt = 0;

    task automatic finish_beat();
        chk(len == cur.len, cur.wr ? "R5" : (cur.gap == -2 ? "R3" : "R2"),
            "strobe length", len, cur.len);
        if (cur.wr) chk(wok, "R5", "write data driven during strobe", wok, 1);
        last_wr = cur.wr;
        in_beat = 0;
    endtask

    task automatic start_beat(input bit cont);
        if (bq.size() == 0) begin
            chk(0, "R9", "strobe without accepted request", mem_addr, 0);
            cur.wr = !mem_we_n; cur.addr = mem_addr; cur.len = -1; cur.gap = -1;
        end else begin
            cur = bq.pop_front();
            if (cont)
                chk(cur.gap == -2, "R6", "unexpected page continuation", 1, 0);
            else if (cur.gap == -2)
                chk(0, "R3", "page continuation expected, gap seen", gapcnt, 0);
            else if (cur.gap >= 0)
                chk(gapcnt == cur.gap, "R4", "strobe-free clocks", gapcnt, cur.gap);
            chk(cur.addr == mem_addr, "R9", "beat address", mem_addr, cur.addr);
            chk(cur.wr == !mem_we_n, "R5", "beat kind", !mem_we_n, cur.wr);
        end
        len = 0;
        wok = 1;
        in_beat = 1;
    endtask

    // Monitor and scoreboard, sampled one unit after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && mon_on) begin
                if (rsp_valid) begin
                    if (rq.size() == 0) chk(0, "R2", "unexpected response", rsp_rdata, 0);
                    else begin
                        logic [DW-1:0] ex;
                        ex = rq.pop_front();
                        chk(rsp_rdata == ex, "R2", "read data", rsp_rdata, ex);
                    end
                end
                if (!hiz_n) begin
                    chk(!mem_addr_oe && !mem_dq_oe && !mem_ctl_oe && !req_ready, "R7",
                        "drivers released while floated",
                        {mem_addr_oe, mem_dq_oe, mem_ctl_oe, req_ready}, 0);
                end else if (!mem_oe_n || !mem_we_n) begin
                    if (!in_beat) start_beat(0);
                    else if (mem_addr != cur.addr || (!mem_we_n) != cur.wr) begin
                        finish_beat();
                        start_beat(1);
                    end
                    len++;
                    if (!mem_we_n) begin
                        wok = wok && mem_dq_oe && (mem_dq_out == cur.data);
                        chk(!req_ready, "R9", "ready during write", req_ready, 0);
                    end
                end else begin
                    if (in_beat) begin
                        finish_beat();
                        gapcnt = 0;
                    end
                    if (last_wr && gapcnt == 0)
                        chk(mem_dq_oe, "R5", "data held first release clock", mem_dq_oe, 1);
                    if (last_wr && gapcnt == 1)
                        chk(!mem_dq_oe, "R5", "data released second clock", mem_dq_oe, 0);
                    gapcnt++;
                end
            end
        end
    end

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(mem_oe_n && mem_we_n, "R1", "strobes idle", {mem_oe_n, mem_we_n}, 3);
        chk(!rsp_valid && !mem_dq_oe, "R1", "no response, data undriven",
            {rsp_valid, mem_dq_oe}, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        @(negedge clk);
        mon_on = 1;

        // R2 R6: random reads to different pages
        issue(0, 26'h0000100, '0);
        issue(0, 26'h0123458, '0);
        issue(0, 26'h3FFFFF0, '0);
        settle();

        // R3: page burst, then page boundary crossing 7 -> 8 (R6)
        issue(0, 26'h0004000, '0);
        issue(0, 26'h0004001, '0);
        issue(0, 26'h0004003, '0);
        issue(0, 26'h0004007, '0);
        issue(0, 26'h0004008, '0);
        issue(0, 26'h0004009, '0);
        settle();

        // R5 R6: writes mixed with reads on one page
        issue(1, 26'h0000200, 16'hBEEF);
        issue(0, 26'h0000201, '0);
        issue(0, 26'h0000202, '0);
        issue(1, 26'h0000203, 16'h1234);
        issue(1, 26'h0000204, 16'h8001);
        issue(0, 26'h0000205, '0);
        settle();

        // R2 R3 R4: all counts at minimum
        cfg_f = 2'd0; cfg_r = 4'd0; cfg_p = 3'd0;
        issue(0, 26'h0010010, '0);
        issue(0, 26'h0010011, '0);
        issue(0, 26'h0010012, '0);
        issue(1, 26'h0010013, 16'h00FF);
        issue(0, 26'h0020000, '0);
        settle();

        // R2 R3 R4 R5: all counts at maximum
        cfg_f = 2'd3; cfg_r = 4'd15; cfg_p = 3'd7;
        issue(0, 26'h1000000, '0);
        issue(0, 26'h1000005, '0);
        issue(1, 26'h1000006, 16'hA5A5);
        issue(0, 26'h2000000, '0);
        settle();

        // R7 R8: float pulses during beats, release and a waiting request
        cfg_f = 2'd1; cfg_r = 4'd3; cfg_p = 3'd2;
        fork
            begin
                issue(0, 26'h0030000, '0);
                issue(0, 26'h0030001, '0);
                issue(0, 26'h0030002, '0);
                issue(1, 26'h0030003, 16'h4242);
                issue(0, 26'h0040000, '0);
                issue(0, 26'h0040004, '0);
            end
            begin
                repeat (2) @(negedge clk);
                hiz_n = 1'b0;
                repeat (5) @(negedge clk);
                hiz_n = 1'b1;
                repeat (6) @(negedge clk);
                hiz_n = 1'b0;
                repeat (3) @(negedge clk);
                hiz_n = 1'b1;
                repeat (9) @(negedge clk);
                hiz_n = 1'b0;
                repeat (4) @(negedge clk);
                hiz_n = 1'b1;
            end
        join
        settle();
        hiz_n = 1'b0;
        @(negedge clk);
        fork
            issue(0, 26'h0050000, '0);
            begin
                repeat (6) @(negedge clk);
                hiz_n = 1'b1;
            end
        join
        settle();

        // R8: every accepted request produced its beat and response
        chk(bq.size() == 0 && !in_beat, "R8", "beats outstanding", bq.size(), 0);
        chk(rq.size() == 0, "R8", "responses outstanding", rq.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "R8", "watchdog expired", 1, 0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule